// File: doc/BRIEF.md
# Period-Match Timer with Postscaled Interrupt

This block is an 8-bit timer that advances on a clock enable running at a quarter of the system oscillator rate. The enable first passes through a prescaler that divides by 1, 4 or 16. The counter counts the prescaled ticks. On the tick where the counter equals a programmable period value, the counter restarts from zero and a match event occurs. This makes the period (period + 1) prescaled ticks long.

Every match event produces a one-cycle unscaled pulse on `match_pulse`. Peer blocks can use this pulse as a PWM time base or as a serial shift clock. The same events also drive a 4-bit postscaler. Each time the postscaler completes, it sets a sticky interrupt flag. The `irq` output is high whenever both the flag and an interrupt enable bit are set.

Software reaches the control, count, period and interrupt registers through a simple write port and a combinational read port, selected by a 2-bit address. Address 0 is control, 1 is count, 2 is period and 3 is interrupt.

Top module: `period_match_timer`

## Requirements
- R1: After reset, the registers read as follows: control 0x00, count 0x00, period 0xFF and interrupt 0x00. Both `match_pulse` and `irq` are low.
- R2: While the timer runs, each prescaled tick increments the count. On a tick where the count equals the period, the count returns to 0 and `match_pulse` goes high for one cycle, one cycle after that tick. With the enable held high, matches are (period+1)×divide cycles apart.
- R3: Control bits 1:0 select the prescaler divide: 00 divides by 1, 01 by 4, and 10 or 11 by 16.
- R4: A period of 0 gives a match on every prescaled tick, and the count stays at 0.
- R5: Control bit 2 is the run bit. While it is 0, the count and the prescaler hold their values and no match pulse occurs.
- R6: When control bits 6:3 hold the value k, the interrupt flag is set on every (k+1)-th match after the postscaler was last cleared. The flag becomes visible in the same cycle as that match pulse.
- R7: The interrupt flag is bit 0 of register 3. It stays set until software writes that bit. A write stores the written bit, so writing 1 also sets the flag. A hardware set in the same cycle as a software clear wins.
- R8: Bit 1 of register 3 is the interrupt enable. `irq` is high exactly when both the flag and the enable are 1.
- R9: A write to the count register loads the written value. A write to the count register or to the control register clears the prescaler and postscaler counts, and suppresses any tick in that cycle.
- R10: Control bit 7 always reads 0. Registers at addresses 0 to 3 read back their contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Instruction-rate clock enable (oscillator / 4) |
| bus_addr | input | 2 | Register select: 0 control, 1 count, 2 period, 3 interrupt |
| bus_wr | input | 1 | Write strobe, takes effect at the next clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| match_pulse | output | 1 | One-cycle unscaled period-match pulse |
| irq | output | 1 | Interrupt request: flag and enable both set |

## Verification
A control write that starts the timer at clock edge e0 leads to a match pulse after edge e0 + m×(period+1)×divide, for every whole m ≥ 1. The flag rises at the edge of every (k+1)-th of those matches.

The driver pushes each of these expected edge numbers into a queue as soon as it starts a run. The monitor samples `match_pulse` at every falling edge, pops the queue head, and compares it with the number of rising edges counted so far. Any pulse that is early, late or extra is reported.

Register effects appear one edge after the write. The effect of a count write on the prescaler appears exactly divide edges after it. The bench checks these reads at falling edges chosen by the same edge count.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int PRE_SEL_W  = 2;
    localparam int POST_SEL_W = 4;
    localparam int PRE_CNT_W  = 4;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_COUNT  = 2'd1,
        ADDR_PERIOD = 2'd2,
        ADDR_IRQ    = 2'd3
    } reg_addr_e;

    // control layout: [6:3] postscale select, [2] run, [1:0] prescale select
    typedef struct packed {
        logic [POST_SEL_W-1:0] post_sel;
        logic                  run;
        logic [PRE_SEL_W-1:0]  pre_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
    import ptmr_pkg::*;
#(
    parameter int CNT_W = PRE_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 run,
    input  logic                 clr,
    input  logic [PRE_SEL_W-1:0] sel,
    output logic                 tick
);

    localparam logic [CNT_W-1:0] TERM_DIV1  = CNT_W'(0);
    localparam logic [CNT_W-1:0] TERM_DIV4  = CNT_W'(3);
    localparam logic [CNT_W-1:0] TERM_DIV16 = CNT_W'(15);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] term;
    logic             adv;

    always_comb begin
        case (sel)
            2'b00:   term = TERM_DIV1;
            2'b01:   term = TERM_DIV4;
            default: term = TERM_DIV16;
        endcase
        adv   = tick_en && run && !clr;
        tick  = adv && (cnt_q == term);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (adv) begin
            cnt_d = tick ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ptmr_postscaler.sv
module ptmr_postscaler
    import ptmr_pkg::*;
#(
    parameter int SEL_W = POST_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             fire
);

    logic [SEL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = ev && !clr && (cnt_q == sel);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (ev) begin
            cnt_d = fire ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/period_match_timer.sv
module period_match_timer
    import ptmr_pkg::*;
#(
    parameter int               CNT_W      = 8,
    parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             match_pulse,
    output logic             irq
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] period;
        logic             flag;
        logic             irq_en;
        logic             match;
    } state_t;

    localparam state_t STATE_RST = '{
        ctrl:   '0,
        count:  '0,
        period: PERIOD_RST,
        flag:   1'b0,
        irq_en: 1'b0,
        match:  1'b0
    };

    state_t    state_d, state_q;
    reg_addr_e addr;
    logic      wr_ctrl, wr_count, wr_period, wr_irq;
    logic      clr_scalers;
    logic      tick;
    logic      match_ev;
    logic      post_fire;

    always_comb begin
        addr        = reg_addr_e'(bus_addr);
        wr_ctrl     = bus_wr && (addr == ADDR_CTRL);
        wr_count    = bus_wr && (addr == ADDR_COUNT);
        wr_period   = bus_wr && (addr == ADDR_PERIOD);
        wr_irq      = bus_wr && (addr == ADDR_IRQ);
        clr_scalers = wr_ctrl || wr_count;
    end

    ptmr_prescaler #(
        .CNT_W (PRE_CNT_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (state_q.ctrl.run),
        .clr     (clr_scalers),
        .sel     (state_q.ctrl.pre_sel),
        .tick    (tick)
    );

    assign match_ev = tick && (state_q.count == state_q.period);

    ptmr_postscaler #(
        .SEL_W (POST_SEL_W)
    ) u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (match_ev),
        .clr   (clr_scalers),
        .sel   (state_q.ctrl.post_sel),
        .fire  (post_fire)
    );

    always_comb begin
        state_d       = state_q;
        state_d.match = match_ev;

        if (tick) begin
            state_d.count = match_ev ? '0 : state_q.count + 1'b1;
        end
        if (wr_count) begin
            state_d.count = bus_wdata;
        end
        if (wr_period) begin
            state_d.period = bus_wdata;
        end
        if (wr_ctrl) begin
            state_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
        if (wr_irq) begin
            state_d.flag   = bus_wdata[0];
            state_d.irq_en = bus_wdata[1];
        end
        // hardware set outranks a same-cycle software write
        if (post_fire) begin
            state_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STATE_RST;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (addr)
            ADDR_CTRL:   bus_rdata = CNT_W'(state_q.ctrl);
            ADDR_COUNT:  bus_rdata = state_q.count;
            ADDR_PERIOD: bus_rdata = state_q.period;
            default:     bus_rdata = CNT_W'({state_q.irq_en, state_q.flag});
        endcase
    end

    assign match_pulse = state_q.match;
    assign irq         = state_q.flag && state_q.irq_en;

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             match_pulse,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period,
    input logic             flag
);

    logic wr_count_c, wr_irq_c;
    assign wr_count_c = bus_wr && (bus_addr == 2'd1);
    assign wr_irq_c   = bus_wr && (bus_addr == 2'd3);

    assert_restart_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (count == '0));

    assert_zero_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && period == '0 && count == '0 && !bus_wr) |=> (count == '0));

    assert_no_match_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !match_pulse);

    assert_frozen_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count_c) |=> $stable(count));

    assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (match_pulse || $past(wr_irq_c && bus_wdata[0])));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_irq_c && !bus_wdata[0])) |=> flag);

endmodule

bind period_match_timer ptmr_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .match_pulse (match_pulse),
    .run         (state_q.ctrl.run),
    .count       (state_q.count),
    .period      (state_q.period),
    .flag        (state_q.flag)
);

// File: tb/tb_period_match_timer.sv
module tb_period_match_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       match_pulse;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;
    int exp_q[$];

    period_match_timer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .match_pulse (match_pulse),
        .irq         (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: every match pulse must be the next expected one
    always @(negedge clk) begin
        if (rst_n && !done && match_pulse) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected match", cyc, -1);
            end else begin
                check("R2 match timing", cyc, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // write takes effect at the next posedge; returns at the following negedge
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    function automatic int divide(input int pre);
        if (pre == 0) return 1;
        else if (pre == 1) return 4;
        else return 16;
    endfunction

    // driver: start a run, push expected match edges, stop after n edges
    task automatic timed_run(input int pre, input int post, input int per, input int n);
        int e0;
        int step;
        bus_write(2'd2, 8'(per));
        bus_write(2'd1, 8'd0);
        bus_write(2'd0, 8'((post << 3) | 4 | pre));
        e0   = cyc;
        step = (per + 1) * divide(pre);
        for (int m = 1; m * step < n; m++) exp_q.push_back(e0 + m * step);
        wait_until(e0 + n - 1);
        bus_write(2'd0, 8'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, v2, e0, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 count", v, 0);
        rd(2'd2, v); check("R1 period", v, 255);
        rd(2'd3, v); check("R1 irq reg", v, 0);
        check("R1 match_pulse", int'(match_pulse), 0);
        check("R1 irq", int'(irq), 0);

        // R10 control bit 7 reads 0
        bus_write(2'd0, 8'h80);
        rd(2'd0, v); check("R10 ctrl bit7", v, 0);
        bus_write(2'd2, 8'h5A);
        rd(2'd2, v); check("R10 period readback", v, 8'h5A);

        // R2/R3 divide by 1, period 3
        timed_run(0, 0, 3, 20);
        // R3 divide by 4, period 2
        timed_run(1, 0, 2, 50);
        // R3 code 11 divides by 16; R4 period 0
        timed_run(3, 0, 0, 70);
        // R3 code 10 also divides by 16
        timed_run(2, 0, 1, 70);

        // R5 stopped: count frozen, no matches (scoreboard catches any)
        rd(2'd1, v);
        repeat (30) @(negedge clk);
        rd(2'd1, v2);
        check("R5 count frozen", v2, v);
        check("R5 queue drained", exp_q.size(), 0);

        // R6/R8 postscale 1:3, period 1, irq enabled
        bus_write(2'd3, 8'h02);
        bus_write(2'd2, 8'd1);
        bus_write(2'd1, 8'd0);
        bus_write(2'd0, 8'((2 << 3) | 4));
        e0 = cyc;
        for (int m = 1; m * 2 < 20; m++) exp_q.push_back(e0 + m * 2);
        wait_until(e0 + 5);
        check("R6 irq before 3rd match", int'(irq), 0);
        wait_until(e0 + 6);
        check("R6 irq at 3rd match", int'(irq), 1);
        rd(2'd3, v); check("R6 flag set", v, 3);
        wait_until(e0 + 19);
        bus_write(2'd0, 8'd0);
        repeat (5) @(negedge clk);
        rd(2'd3, v); check("R7 flag sticky", v, 3);
        bus_write(2'd3, 8'h02);
        rd(2'd3, v); check("R7 software clear", v, 2);
        check("R8 irq low after clear", int'(irq), 0);
        bus_write(2'd3, 8'h01);
        check("R8 irq masked", int'(irq), 0);
        rd(2'd3, v); check("R7 software set", v, 1);
        bus_write(2'd3, 8'h00);

        // R7 hardware set beats software clear (period 0, 1:1, post 1:1)
        bus_write(2'd2, 8'd0);
        bus_write(2'd1, 8'd0);
        bus_write(2'd0, 8'h04);
        e0 = cyc;
        for (int m = 1; m < 6; m++) exp_q.push_back(e0 + m);
        wait_until(e0 + 2);
        bus_write(2'd3, 8'h00);
        rd(2'd3, v); check("R7 hw set wins", v, 1);
        rd(2'd1, v); check("R4 count stays 0", v, 0);
        wait_until(e0 + 5);
        bus_write(2'd0, 8'd0);
        bus_write(2'd3, 8'h00);
        rd(2'd3, v); check("R7 cleared when idle", v, 0);

        // R9 count write loads value and restarts the prescaler
        bus_write(2'd2, 8'd200);
        bus_write(2'd1, 8'd0);
        bus_write(2'd0, 8'h05);
        e0 = cyc;
        wait_until(e0 + 5);
        bus_write(2'd1, 8'd5);
        w = cyc;
        rd(2'd1, v); check("R9 count load", v, 5);
        wait_until(w + 3);
        rd(2'd1, v); check("R9 no tick before 4 edges", v, 5);
        wait_until(w + 4);
        rd(2'd1, v); check("R9 tick after prescaler clear", v, 6);
        bus_write(2'd0, 8'd0);

        repeat (4) @(negedge clk);
        check("R2 all expected matches seen", exp_q.size(), 0);
        finish_run();
    end

endmodule